// File: doc/BRIEF.md
# Programmable Loss-of-Signal Detector

This block watches a serial receive bit stream, taking one bit each time the recovered-clock strobe is high. A zero bit counts as an empty bit period, with no pulse in it. When the number of empty periods in a row reaches a length set by software, the block raises a loss-of-signal alarm. That length is the detection register plus one, times sixteen.

While the alarm is up, the block counts the one bits it sees. The alarm drops on the bit in which that count reaches the value in the recovery register. If another full-length run of zeros arrives before then, the count of ones starts again from zero.

An auto-clear control can force the forwarded data to zero for as long as the alarm is up. This keeps corrupted bits away from the logic downstream.

Top module: `los_detector`

## Requirements
- R1: After reset, `los_alarm` and `rx_out` are 0, and both internal counters (the zero-run count and the ones count) are zero.
- R2: State changes only on a clock edge where `bit_stb` is 1. With `bit_stb` at 0, `los_alarm` and `rx_out` hold whatever `rx_bit` does.
- R3: With `det_len_cfg` = D, `los_alarm` goes to 1 on the strobe that accepts the (D+1)*16-th zero in a row, and not before it. D=0 gives 16 and D=255 gives 4096.
- R4: Any accepted one bit sets the zero-run count back to zero, so zeros only count when they are consecutive. The zero-run count saturates at its maximum and never wraps.
- R5: While the alarm is active, each accepted one bit increments a ones count. The alarm clears on the strobe where that count reaches `rec_cnt_cfg` (1 to 255). A value of 0 acts as 1. Zero runs shorter than the detection length do not reset the ones count.
- R6: While the alarm is active, a new run of zeros as long as the detection length resets the ones count to zero.
- R7: With `auto_clear` at 1, `rx_out` is 0 for every bit accepted while the alarm is active. This includes the bit that raises the alarm and the bit that clears it. The next bit after the clearing bit passes through unchanged.
- R8: `rx_out` is registered. On each strobe it takes the accepted bit, subject to R7. With `auto_clear` at 0 it always equals the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | Bit-valid strobe, one per recovered bit period |
| rx_bit | input | 1 | Received data bit; 0 means no pulse |
| det_len_cfg | input | 8 | Detection length D; the run is (D+1)*16 zeros |
| rec_cnt_cfg | input | 8 | Number of ones needed to clear the alarm (0 acts as 1) |
| auto_clear | input | 1 | 1: force output data to zero while the alarm is active |
| los_alarm | output | 1 | Loss-of-signal alarm |
| rx_out | output | 1 | Forwarded data, registered, possibly gated |

## Verification
The bench builds the block with its default parameters: an 8-bit register width and a scale of sixteen. This puts both ends of the detection range, 16 and 4096 bit periods, within reach of the run. It sweeps several detection and recovery settings, including recovery value 0. At each one it probes the bit just before and the bit exactly at the alarm edge, and the bit just before and exactly at the recovery edge. Runs of zeros broken by a one, and re-armed recovery runs, show counter restarts at the ports. Long gaps between strobes and both auto-clear settings test the hold behaviour and the output gating.

// File: rtl/los_pkg.sv
package los_pkg;
  localparam int unsigned CFG_W_DEF      = 8;
  localparam int unsigned SCALE_LOG2_DEF = 4;

  // Number of consecutive empty bit periods that raise the alarm.
  function automatic int unsigned run_limit(input int unsigned det, input int unsigned scale_log2);
    return (det + 1) << scale_log2;
  endfunction

  // Ones needed to drop the alarm; zero is promoted to one.
  function automatic int unsigned ones_target(input int unsigned rec);
    return (rec == 0) ? 1 : rec;
  endfunction
endpackage

// File: rtl/los_zero_run.sv
module los_zero_run
  import los_pkg::*;
#(
  parameter int unsigned CFG_W      = CFG_W_DEF,
  parameter int unsigned SCALE_LOG2 = SCALE_LOG2_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             bit_i,
  input  logic [CFG_W-1:0] det,
  output logic             run_full
);
  localparam int unsigned ZW = CFG_W + SCALE_LOG2 + 1;
  localparam logic [ZW-1:0] ZMAX = {ZW{1'b1}};

  logic [ZW-1:0] zcnt, zcnt_nxt, limit;

  assign limit = ZW'(run_limit(int'(det), SCALE_LOG2));

  always_comb begin
    if (bit_i)             zcnt_nxt = '0;
    else if (zcnt == ZMAX) zcnt_nxt = ZMAX;
    else                   zcnt_nxt = zcnt + 1'b1;
  end

  assign run_full = stb & ~bit_i & (zcnt_nxt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   zcnt <= '0;
    else if (stb) zcnt <= zcnt_nxt;
  end

  // R4: an accepted one empties the run
  a_r4_one_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && bit_i) |=> (zcnt == '0));
  // R4: no wrap at the top
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !bit_i && zcnt == ZMAX) |=> (zcnt == ZMAX));
  // R2: no strobe, no movement
  a_r2_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(zcnt));
endmodule

// File: rtl/los_recover.sv
module los_recover
  import los_pkg::*;
#(
  parameter int unsigned CFG_W = CFG_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             bit_i,
  input  logic             active,
  input  logic             rearm,
  input  logic [CFG_W-1:0] rec,
  output logic             done
);
  logic [CFG_W-1:0] ocnt;
  logic [CFG_W:0]   ones_nxt, target;
  logic             one_ev;

  assign target   = (CFG_W+1)'(ones_target(int'(rec)));
  assign one_ev   = stb & bit_i & active;
  assign ones_nxt = {1'b0, ocnt} + 1'b1;
  assign done     = one_ev & (ones_nxt >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ocnt <= '0;
    else if (!active || rearm || done) ocnt <= '0;
    else if (one_ev)               ocnt <= ocnt + 1'b1;
  end

  // R6: a renewed full zero run restarts the ones count
  a_r6_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && active) |=> (ocnt == '0));
  // R5: a zero never advances the ones count
  a_r5_zero_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !bit_i) |=> (ocnt == '0 || ocnt == $past(ocnt)));
endmodule

// File: rtl/los_detector.sv
module los_detector
  import los_pkg::*;
#(
  parameter int unsigned CFG_W      = CFG_W_DEF,
  parameter int unsigned SCALE_LOG2 = SCALE_LOG2_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             rx_bit,
  input  logic [CFG_W-1:0] det_len_cfg,
  input  logic [CFG_W-1:0] rec_cnt_cfg,
  input  logic             auto_clear,
  output logic             los_alarm,
  output logic             rx_out
);
  logic run_full, set_ev, rearm_ev, clear_ev, gate;

  los_zero_run #(.CFG_W(CFG_W), .SCALE_LOG2(SCALE_LOG2)) u_run (
    .clk(clk), .rst_n(rst_n), .stb(bit_stb), .bit_i(rx_bit),
    .det(det_len_cfg), .run_full(run_full)
  );

  assign set_ev   = run_full & ~los_alarm;
  assign rearm_ev = run_full & los_alarm;

  los_recover #(.CFG_W(CFG_W)) u_rec (
    .clk(clk), .rst_n(rst_n), .stb(bit_stb), .bit_i(rx_bit),
    .active(los_alarm), .rearm(rearm_ev), .rec(rec_cnt_cfg), .done(clear_ev)
  );

  assign gate = auto_clear & (los_alarm | set_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_alarm <= 1'b0;
      rx_out    <= 1'b0;
    end else if (bit_stb) begin
      rx_out <= rx_bit & ~gate;
      if (set_ev)        los_alarm <= 1'b1;
      else if (clear_ev) los_alarm <= 1'b0;
    end
  end

  // R3: alarm only rises on an accepted zero
  a_r3_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_alarm) |-> $past(bit_stb && !rx_bit));
  // R5: alarm only falls on an accepted one
  a_r5_fall_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_alarm) |-> $past(bit_stb && rx_bit));
  // R2: outputs hold between strobes
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> ($stable(los_alarm) && $stable(rx_out)));
  // R7: gated output while alarm active
  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && auto_clear && los_alarm) |=> !rx_out);
  // R8: transparent when auto-clear off
  a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !auto_clear) |=> (rx_out == $past(rx_bit)));
endmodule

// File: tb/sim_los_detector.sv
`timescale 1ns/1ps
module sim_los_detector;
  logic clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0, rx_bit = 1'b0, auto_clear = 1'b0;
  logic [7:0] det_len_cfg = 8'd0, rec_cnt_cfg = 8'd0;
  logic los_alarm, rx_out;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  los_detector u0 (.clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .det_len_cfg(det_len_cfg), .rec_cnt_cfg(rec_cnt_cfg), .auto_clear(auto_clear),
    .los_alarm(los_alarm), .rx_out(rx_out));

  function automatic int span(input int d); return (d + 1) * 16; endfunction
  function automatic int need(input int r); return (r == 0) ? 1 : r; endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic b);
    @(negedge clk); bit_stb = 1'b1; rx_bit = b;
    @(negedge clk); bit_stb = 1'b0;
  endtask

  task automatic send_n(input logic b, input int n);
    for (int i = 0; i < n; i++) send(b);
  endtask

  task automatic do_reset;
    bit_stb = 1'b0; rx_bit = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int dets[4] = '{0, 1, 3, 255};
    int recs[4] = '{0, 1, 3, 5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 alarm", los_alarm, 1'b0);
    chk("R1 data", rx_out, 1'b0);
    // R1: counters start at zero: exactly 16 zeros needed with D=0
    send_n(1'b0, 15); chk("R1 run", los_alarm, 1'b0);

    // Sweep detection x recovery (R3, R5, R7)
    for (int di = 0; di < 4; di++) begin
      for (int ri = 0; ri < 4; ri++) begin
        if (di == 3 && ri > 1) continue;
        det_len_cfg = 8'(dets[di]); rec_cnt_cfg = 8'(recs[ri]); auto_clear = 1'b1;
        do_reset;
        send_n(1'b0, span(dets[di]) - 1);
        chk("R3 before edge", los_alarm, 1'b0);
        send(1'b0);
        chk("R3 at edge", los_alarm, 1'b1);
        chk("R7 raise bit", rx_out, 1'b0);
        send_n(1'b1, need(recs[ri]) - 1);
        chk("R5 before clear", los_alarm, 1'b1);
        chk("R7 gated one", rx_out, 1'b0);
        send(1'b1);
        chk("R5 at clear", los_alarm, 1'b0);
        chk("R7 clearing bit gated", rx_out, 1'b0);
        send(1'b1);
        chk("R7 after clear passes", rx_out, 1'b1);
      end
    end

    // R4: a one breaks the zero run
    det_len_cfg = 8'd1; rec_cnt_cfg = 8'd3; auto_clear = 1'b0;
    do_reset;
    send_n(1'b0, 31); send(1'b1); send_n(1'b0, 31);
    chk("R4 broken run", los_alarm, 1'b0);
    send(1'b0);
    chk("R4 full run", los_alarm, 1'b1);

    // R8: with auto_clear off, ones pass during alarm
    send(1'b1);
    chk("R8 pass during alarm", rx_out, 1'b1);
    // R5: short zero run does not reset ones count (1 so far)
    send_n(1'b0, 20); send(1'b1);
    chk("R5 count kept (2 of 3)", los_alarm, 1'b1);
    send(1'b1);
    chk("R5 third one clears", los_alarm, 1'b0);

    // R6: full zero run during alarm restarts ones count
    send_n(1'b0, 32);
    chk("R6 alarm again", los_alarm, 1'b1);
    send_n(1'b1, 2); send_n(1'b0, 32); send_n(1'b1, 2);
    chk("R6 count restarted", los_alarm, 1'b1);
    send(1'b1);
    chk("R6 clears after 3", los_alarm, 1'b0);

    // R2: no strobe, nothing moves
    send_n(1'b0, 32);
    chk("R2 alarm set", los_alarm, 1'b1);
    @(negedge clk); rx_bit = 1'b1;
    repeat (50) @(posedge clk);
    @(negedge clk);
    chk("R2 alarm held", los_alarm, 1'b1);
    chk("R2 data held", rx_out, 1'b0);

    // R4: long run past saturation, then recovery and a fresh run
    det_len_cfg = 8'd255; rec_cnt_cfg = 8'd1; auto_clear = 1'b1;
    do_reset;
    send_n(1'b0, 9000);
    chk("R4 long run alarm", los_alarm, 1'b1);
    send(1'b1);
    chk("R4 recover after long run", los_alarm, 1'b0);
    send_n(1'b0, 4095);
    chk("R4 fresh run below limit", los_alarm, 1'b0);
    send(1'b0);
    chk("R4 fresh run at limit", los_alarm, 1'b1);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule